// File: doc/BRIEF.md
# Timer Compare Status and Output Control

This block holds the status and control register for one 8-bit timer channel. It watches the count value of an external up-counter and two compare constants, A and B. The block raises three sticky flags: a match against A, a match against B, and a wrap of the counter from its all-ones value to zero. Each match can also act on a single timer output pin, and a match on A can send a one-clock start request to an A/D converter.

Software reads and writes one 8-bit register through a read strobe, a write strobe and a data bus. A flag clears only in two ways. Software can read the register while the flag is 1 and then write 0 to that bit. A transfer controller can also acknowledge the matching event while its disable-select input is low. The parameter `CHAN` picks one of two variants. In variant 0, bit 4 is a writable A/D trigger enable. In variant 1, bit 4 is fixed at 1.

Top module: `tcsr_top`

## Requirements
- R1: After reset the register reads 0x00 in variant 0 and 0x10 in variant 1, `tmrOut` is 0 and `adcStart` is 0.
- R2: When `cnt` becomes equal to `cmpA`, bit 6 is set at the next clock edge. When `cnt` becomes equal to `cmpB`, bit 7 is set at the next clock edge.
- R3: When `cnt` is 0xFF in one cycle and 0x00 in the next, bit 5 is set at the following edge.
- R4: Writing 1 to bits 7..5 leaves them unchanged. Writing 0 to a flag that was not armed also leaves it unchanged. A flag is armed only by a read made while it was 1, and any write discards all arming.
- R5: A flag that was read as 1 clears when the next write puts 0 in its bit.
- R6: Bits 1..0 select the pin action on a match against A, and bits 3..2 select the action on a match against B. The codes are 00 hold, 01 drive 0, 10 drive 1 and 11 invert. The pin changes at the clock edge that ends the match cycle.
- R7: In variant 0, bit 4 is read/write. While bit 4 is 1, each match against A produces a `adcStart` pulse exactly one clock long. While bit 4 is 0, no pulse is produced.
- R8: In variant 1, bit 4 always reads 1 and ignores writes, and `adcStart` stays 0.
- R9: `dtcAckA` or `dtcAckB` clears bit 6 or bit 7 respectively when `dtcDisSel` is 0. When `dtcDisSel` is 1 it has no effect.
- R10: If a flag's set condition and a clear request for that flag land in the same cycle, the flag stays 1.
- R11: If matches against A and B happen in the same cycle, the action selected for B is the one applied to the pin.
- R12: A match is an event on the cycle where equality begins. Holding the counter equal to a constant for further cycles triggers no further action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cnt | input | 8 | Current counter value |
| cmpA | input | 8 | Compare constant A |
| cmpB | input | 8 | Compare constant B |
| rdStb | input | 1 | Register read strobe |
| wrStb | input | 1 | Register write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Register read value |
| dtcAckA | input | 1 | Transfer controller serviced match A |
| dtcAckB | input | 1 | Transfer controller serviced match B |
| dtcDisSel | input | 1 | Transfer controller disable-select; 1 blocks flag clearing |
| tmrOut | output | 1 | Timer output pin |
| adcStart | output | 1 | A/D converter start request pulse |

## Verification
The assertions check several rules on every cycle. A flag may fall only after a write of 0 to its bit or a permitted acknowledge. A flag may rise only after equality with its constant. The pin may change only after an equality. `adcStart` is never longer than one clock and needs the enable. In variant 1, bit 4 stays at 1. Some behaviours can only be shown by the bench's scenarios: the read-before-write arming, the exact code-to-action mapping, the B-over-A priority when both match, the set-wins collision, and the fact that a held equality fires only once.

// File: rtl/tcsr_pkg.sv
package tcsr_pkg;

  typedef struct packed {
    logic cmB;
    logic cmA;
    logic ovf;
  } tcsr_evt_t;

  localparam int FLAG_LSB = 5;
  localparam int NUM_FLAGS = 3;
  localparam int SEL_BIT = 4;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } pin_act_e;

  function automatic logic applyAct(input logic [1:0] act, input logic cur);
    case (pin_act_e'(act))
      ACT_LOW:  applyAct = 1'b0;
      ACT_HIGH: applyAct = 1'b1;
      ACT_FLIP: applyAct = ~cur;
      default:  applyAct = cur;
    endcase
  endfunction

endpackage

// File: rtl/tcsr_detect.sv
module tcsr_detect
  import tcsr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] cmpB,
  output tcsr_evt_t        evt
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] CNT_BOT = '0;

  logic [CNT_W-1:0] prevCnt;
  logic eqA, eqB, eqAq, eqBq, primed;

  assign eqA = (cnt == cmpA);
  assign eqB = (cnt == cmpB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCnt <= '0;
      eqAq    <= 1'b0;
      eqBq    <= 1'b0;
      primed  <= 1'b0;
    end else begin
      prevCnt <= cnt;
      eqAq    <= eqA;
      eqBq    <= eqB;
      primed  <= 1'b1;
    end
  end

  // an event is the first cycle of equality or a wrap
  always_comb begin
    evt.cmA = primed && eqA && !eqAq;
    evt.cmB = primed && eqB && !eqBq;
    evt.ovf = primed && (prevCnt == CNT_TOP) && (cnt == CNT_BOT);
  end

endmodule

// File: rtl/tcsr_regs.sv
module tcsr_regs
  import tcsr_pkg::*;
#(
  parameter int CHAN   = 0,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tcsr_evt_t         evt,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dtcAckA,
  input  logic              dtcAckB,
  input  logic              dtcDisSel,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        osA,
  output logic [1:0]        osB,
  output logic              trigEn
);
  localparam logic SEL_RST = (CHAN == 0) ? 1'b0 : 1'b1;

  logic [NUM_FLAGS-1:0] flagQ, armQ, setVec, extClr;
  logic [3:0] osQ;
  logic selQ;

  assign setVec = {evt.cmB, evt.cmA, evt.ovf};
  assign extClr = {dtcAckB && !dtcDisSel, dtcAckA && !dtcDisSel, 1'b0};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic swClr;
    assign swClr = wrStb && armQ[i] && !wrData[FLAG_LSB+i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagQ[i] <= 1'b0;
        armQ[i]  <= 1'b0;
      end else begin
        flagQ[i] <= setVec[i] || (flagQ[i] && !(swClr || extClr[i]));
        if (wrStb)      armQ[i] <= 1'b0;
        else if (rdStb) armQ[i] <= flagQ[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      osQ  <= '0;
      selQ <= SEL_RST;
    end else if (wrStb) begin
      osQ  <= wrData[3:0];
      selQ <= (CHAN == 0) ? wrData[SEL_BIT] : 1'b1;
    end
  end

  assign rdData = {flagQ, selQ, osQ};
  assign osA    = osQ[1:0];
  assign osB    = osQ[3:2];
  assign trigEn = (CHAN == 0) && selQ;

endmodule

// File: rtl/tcsr_pin.sv
module tcsr_pin
  import tcsr_pkg::*;
#(
  parameter int CHAN = 0
) (
  input  logic      clk,
  input  logic      rstN,
  input  tcsr_evt_t evt,
  input  logic [1:0] osA,
  input  logic [1:0] osB,
  input  logic      trigEn,
  output logic      tmrOut,
  output logic      adcStart
);
  logic pinNext;

  // B takes priority when both matches fall in one cycle
  always_comb begin
    pinNext = tmrOut;
    if (evt.cmB)      pinNext = applyAct(osB, tmrOut);
    else if (evt.cmA) pinNext = applyAct(osA, tmrOut);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tmrOut <= 1'b0;
    else       tmrOut <= pinNext;
  end

  if (CHAN == 0) begin : g_adc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) adcStart <= 1'b0;
      else       adcStart <= evt.cmA && trigEn;
    end
  end else begin : g_noadc
    logic unusedTrig;
    assign unusedTrig = trigEn;
    assign adcStart = 1'b0 & unusedTrig;
  end

endmodule

// File: rtl/tcsr_top.sv
module tcsr_top
  import tcsr_pkg::*;
#(
  parameter int CHAN  = 0,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] cmpB,
  input  logic             rdStb,
  input  logic             wrStb,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  input  logic             dtcAckA,
  input  logic             dtcAckB,
  input  logic             dtcDisSel,
  output logic             tmrOut,
  output logic             adcStart
);
  tcsr_evt_t evt;
  logic [1:0] osA, osB;
  logic trigEn;

  tcsr_detect #(.CNT_W(CNT_W)) u_detect (
    .clk(clk), .rstN(rstN), .cnt(cnt), .cmpA(cmpA), .cmpB(cmpB), .evt(evt)
  );

  tcsr_regs #(.CHAN(CHAN), .DATA_W(8)) u_regs (
    .clk(clk), .rstN(rstN), .evt(evt), .rdStb(rdStb), .wrStb(wrStb),
    .wrData(wrData), .dtcAckA(dtcAckA), .dtcAckB(dtcAckB),
    .dtcDisSel(dtcDisSel), .rdData(rdData), .osA(osA), .osB(osB),
    .trigEn(trigEn)
  );

  tcsr_pin #(.CHAN(CHAN)) u_pin (
    .clk(clk), .rstN(rstN), .evt(evt), .osA(osA), .osB(osB),
    .trigEn(trigEn), .tmrOut(tmrOut), .adcStart(adcStart)
  );

endmodule

// File: rtl/tcsr_checker.sv
module tcsr_checker #(
  parameter int CHAN  = 0,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmpA,
  input logic [CNT_W-1:0] cmpB,
  input logic             wrStb,
  input logic [7:0]       wrData,
  input logic [7:0]       rdData,
  input logic             dtcAckA,
  input logic             dtcAckB,
  input logic             dtcDisSel,
  input logic             tmrOut,
  input logic             adcStart
);
  assert_rise_a_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[6]) |-> $past(cnt == cmpA));
  assert_rise_b_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[7]) |-> $past(cnt == cmpB));
  assert_fall_ovf_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdData[5]) |-> $past(wrStb && !wrData[5]));
  assert_fall_a_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdData[6]) |-> $past((wrStb && !wrData[6]) || (dtcAckA && !dtcDisSel)));
  assert_fall_b_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdData[7]) |-> $past((wrStb && !wrData[7]) || (dtcAckB && !dtcDisSel)));
  assert_pin_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tmrOut != $past(tmrOut)) |-> $past((cnt == cmpA) || (cnt == cmpB)));
  assert_adc_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);
  assert_adc_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> $past(rdData[4] && (cnt == cmpA)));
  if (CHAN != 0) begin : g_fixed
    assert_fixed_bit_R8: assert property (@(posedge clk) disable iff (!rstN)
      rdData[4] && !adcStart);
  end
endmodule

bind tcsr_top tcsr_checker #(.CHAN(CHAN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cnt(cnt), .cmpA(cmpA), .cmpB(cmpB),
  .wrStb(wrStb), .wrData(wrData), .rdData(rdData), .dtcAckA(dtcAckA),
  .dtcAckB(dtcAckB), .dtcDisSel(dtcDisSel), .tmrOut(tmrOut),
  .adcStart(adcStart)
);

// File: tb/tcsr_top_test.sv
module tcsr_top_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] cnt = 8'h10, cmpA = 8'h40, cmpB = 8'h80;
  logic rdStb = 1'b0, wrStb = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic dtcAckA = 1'b0, dtcAckB = 1'b0, dtcDisSel = 1'b0;
  logic [7:0] rdData, rdDataAlt;
  logic tmrOut, tmrOutAlt, adcStart, adcStartAlt;

  int checks = 0;
  int fails = 0;

  always #(PERIOD/2) clk = ~clk;

  tcsr_top #(.CHAN(0)) uut (
    .clk(clk), .rstN(rstN), .cnt(cnt), .cmpA(cmpA), .cmpB(cmpB),
    .rdStb(rdStb), .wrStb(wrStb), .wrData(wrData), .rdData(rdData),
    .dtcAckA(dtcAckA), .dtcAckB(dtcAckB), .dtcDisSel(dtcDisSel),
    .tmrOut(tmrOut), .adcStart(adcStart)
  );

  tcsr_top #(.CHAN(1)) uutAlt (
    .clk(clk), .rstN(rstN), .cnt(cnt), .cmpA(cmpA), .cmpB(cmpB),
    .rdStb(rdStb), .wrStb(wrStb), .wrData(wrData), .rdData(rdDataAlt),
    .dtcAckA(dtcAckA), .dtcAckB(dtcAckB), .dtcDisSel(dtcDisSel),
    .tmrOut(tmrOutAlt), .adcStart(adcStartAlt)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] v);
    @(negedge clk) cnt = v;
    @(negedge clk);
  endtask

  task automatic regWrite(input logic [7:0] v);
    @(negedge clk) begin wrStb = 1'b1; wrData = v; end
    @(negedge clk) wrStb = 1'b0;
  endtask

  task automatic regRead();
    @(negedge clk) rdStb = 1'b1;
    @(negedge clk) rdStb = 1'b0;
  endtask

  task automatic tReset();
    check("R1 rd ch0", rdData, 8'h00);
    check("R1 rd ch1", rdDataAlt, 8'h10);
    check("R1 pin", {7'b0, tmrOut}, 8'h00);
    check("R1 adc", {7'b0, adcStart}, 8'h00);
  endtask

  task automatic tMatchFlags();
    step(8'h40);
    check("R2 flag A", rdData, 8'h40);
    regWrite(8'hE0);
    check("R4 write ones", rdData, 8'h40);
    regWrite(8'h00);
    check("R4 unarmed zero", rdData, 8'h40);
    regRead();
    regWrite(8'hE0);
    check("R4 armed ones", rdData, 8'h40);
    regWrite(8'h00);
    check("R4 arm discarded", rdData, 8'h40);
    regRead();
    regWrite(8'h00);
    check("R5 clear A", rdData, 8'h00);
    step(8'h80);
    check("R2 flag B", rdData, 8'h80);
    step(8'hFF);
    step(8'h00);
    check("R3 overflow", rdData, 8'hA0);
    regRead();
    regWrite(8'h00);
    check("R5 clear all", rdData, 8'h00);
  endtask

  task automatic tActions();
    regWrite(8'h02);
    step(8'h40);
    check("R6 A high", {7'b0, tmrOut}, 8'h01);
    regWrite(8'h03);
    step(8'h41);
    step(8'h40);
    check("R6 A toggle", {7'b0, tmrOut}, 8'h00);
    step(8'h40);
    step(8'h40);
    check("R12 held equal", {7'b0, tmrOut}, 8'h00);
    regWrite(8'h00);
    step(8'h41);
    step(8'h40);
    check("R6 A hold", {7'b0, tmrOut}, 8'h00);
    regWrite(8'h03);
    step(8'h41);
    step(8'h40);
    check("R6 A toggle up", {7'b0, tmrOut}, 8'h01);
    regWrite(8'h01);
    step(8'h41);
    step(8'h40);
    check("R6 A low", {7'b0, tmrOut}, 8'h00);
    regWrite(8'h0C);
    step(8'h80);
    check("R6 B toggle", {7'b0, tmrOut}, 8'h01);
  endtask

  task automatic tSimultaneous();
    step(8'h41);
    @(negedge clk) cmpB = 8'h40;
    regWrite(8'h06);
    step(8'h40);
    check("R11 B low wins", {7'b0, tmrOut}, 8'h00);
    regWrite(8'h09);
    step(8'h41);
    step(8'h40);
    check("R11 B high wins", {7'b0, tmrOut}, 8'h01);
    step(8'h41);
    @(negedge clk) cmpB = 8'h80;
  endtask

  task automatic tTrigger();
    regRead();
    regWrite(8'h10);
    check("R7 enable reads", rdData, 8'h10);
    check("R8 fixed bit", rdDataAlt, 8'h10);
    step(8'h40);
    check("R7 pulse", {7'b0, adcStart}, 8'h01);
    check("R8 no pulse", {7'b0, adcStartAlt}, 8'h00);
    @(negedge clk);
    check("R7 one clock", {7'b0, adcStart}, 8'h00);
    regWrite(8'h00);
    check("R7 disable", rdData, 8'h40);
    check("R8 write ignored", rdDataAlt, 8'h50);
    step(8'h41);
    step(8'h40);
    check("R7 no pulse off", {7'b0, adcStart}, 8'h00);
  endtask

  task automatic tAck();
    @(negedge clk) begin dtcAckA = 1'b1; dtcDisSel = 1'b1; end
    @(negedge clk) begin dtcAckA = 1'b0; dtcDisSel = 1'b0; end
    check("R9 blocked", rdData, 8'h40);
    @(negedge clk) dtcAckA = 1'b1;
    @(negedge clk) dtcAckA = 1'b0;
    check("R9 clear A", rdData, 8'h00);
    step(8'h80);
    check("R2 B again", rdData, 8'h80);
    @(negedge clk) dtcAckB = 1'b1;
    @(negedge clk) dtcAckB = 1'b0;
    check("R9 clear B", rdData, 8'h00);
  endtask

  task automatic tSetWins();
    step(8'h40);
    step(8'h41);
    regRead();
    begin wrStb = 1'b1; wrData = 8'h00; cnt = 8'h40; end
    @(negedge clk) wrStb = 1'b0;
    check("R10 write vs set", rdData & 8'h40, 8'h40);
    step(8'h41);
    begin dtcAckA = 1'b1; cnt = 8'h40; end
    @(negedge clk) dtcAckA = 1'b0;
    check("R10 ack vs set", rdData & 8'h40, 8'h40);
  endtask

  initial begin
    #(PERIOD * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tMatchFlags();
    tActions();
    tSimultaneous();
    tTrigger();
    tAck();
    tSetWins();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule